// File: doc/BRIEF.md
# Stream Cipher Key Scheduler

This block prepares the 256-byte permutation table that a byte-oriented stream cipher consumes. After a start request it first writes the identity permutation into an external single-port state memory. It then walks the table once. For each index it mixes in one byte of a 24-bit key and exchanges two entries. When the walk ends it raises a one-cycle completion pulse, which can launch the following keystream stage.

The memory is synchronous. It serves one access per cycle and returns read data one cycle after the address is presented. For this reason the controller spends a wait cycle after every read, and it performs each exchange as two consecutive write cycles. A counter reports how many cycles the whole operation took.

Top module: `ksa_sched`

## Requirements
- R1: Once start is accepted, the first 256 busy cycles write value n to address n for every n from 0 to 255, so that the memory holds the identity permutation before any scrambling write occurs.
- R2: After done, memory entry k equals the result of this procedure: start from the identity, set j = 0, and for i = 0..255 first compute j = (j + S[i] + kb(i mod 3)) mod 256 and then exchange S[i] and S[j].
- R3: The key bytes are kb(0) = key[7:0], kb(1) = key[15:8] and kb(2) = key[23:16]. The j register is 8 bits wide and wraps modulo 256.
- R4: Each index takes exactly 8 cycles. Two of these cycles follow a read and wait for its data. The done pulse therefore appears on the 2305th cycle after the clock edge that accepts start (256 fill cycles, 2048 scramble cycles and 1 done cycle).
- R5: Each exchange is two separate writes: S[j] is written to address i, and then the saved S[i] is written to address j. A run makes exactly 768 writes, and for index 0 the first two scramble writes are (address 0, data key[7:0]) followed by (address key[7:0], data 0).
- R6: done is high for exactly one cycle. The block then returns to idle, makes no further writes and waits for the next start.
- R7: cycles clears when start is accepted and increments once in every busy cycle. After done it holds 2305 until the next start.
- R8: A start asserted while the block is busy is ignored, and the run's timing, counter and memory result are unchanged.
- R9: During and after reset, done and mem_we are low and cycles is 0.
- R10: A new start after done clears j and the counter and reruns both phases, so each run depends only on its own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| key | input | 24 | Scramble key, three bytes |
| mem_addr | output | 8 | State memory address |
| mem_wdata | output | 8 | State memory write data |
| mem_we | output | 1 | State memory write enable |
| mem_rdata | input | 8 | State memory read data, one cycle after address |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | CNT_W | Busy cycle count of the last run |

## Verification
The bench numbers the falling edges after the start-accepting rising edge, so the k-th busy cycle is sampled at count k. The identity table is checked at count 257. This is after the last fill write and before the first exchange write, which lands at count 262. done must appear exactly at count 2305 and nowhere else, and cycles is read at count 2306, once the done cycle has itself been counted. Every write is logged in order, which fixes the exchange order and the total of 768. A stray start injected at counts 1000 to 1001 must leave all of these results unchanged.

// File: rtl/ksa_sched.sv
module ksa_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      key,
  output logic [7:0]       mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  input  logic [7:0]       mem_rdata,
  output logic             done,
  output logic [CNT_W-1:0] cycles
);

  localparam logic [7:0] LAST = 8'hFF;

  typedef enum logic [3:0] {
    IDLE, FILL, RD_I, WT_I, GET_J, RD_J, WT_J, WR_I, WR_J, NEXT, FIN
  } st_t;

  st_t        st;
  logic [7:0] i, j, si, kb;
  logic [1:0] sel;
  logic       busy;

  always_comb begin
    case (sel)
      2'd0:    kb = key[7:0];
      2'd1:    kb = key[15:8];
      default: kb = key[23:16];
    endcase
  end

  assign busy     = (st != IDLE);
  assign done     = (st == FIN);
  assign mem_we   = (st == FILL) || (st == WR_I) || (st == WR_J);
  assign mem_addr = (st == RD_J || st == WT_J || st == WR_J) ? j : i;

  always_comb begin
    case (st)
      WR_I:    mem_wdata = mem_rdata;
      WR_J:    mem_wdata = si;
      default: mem_wdata = i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      i      <= '0;
      j      <= '0;
      si     <= '0;
      sel    <= '0;
      cycles <= '0;
    end else begin
      if (busy) cycles <= cycles + 1'b1;
      case (st)
        IDLE: if (start) begin
          i      <= '0;
          j      <= '0;
          sel    <= '0;
          cycles <= '0;
          st     <= FILL;
        end
        FILL: begin
          i <= i + 1'b1;
          if (i == LAST) st <= RD_I;
        end
        RD_I:  st <= WT_I;
        WT_I:  st <= GET_J;
        GET_J: begin
          si <= mem_rdata;
          j  <= j + mem_rdata + kb;
          st <= RD_J;
        end
        RD_J:  st <= WT_J;
        WT_J:  st <= WR_I;
        WR_I:  st <= WR_J;
        WR_J:  st <= NEXT;
        NEXT: begin
          if (i == LAST) st <= FIN;
          else begin
            i   <= i + 1'b1;
            sel <= (sel == 2'd2) ? 2'd0 : sel + 1'b1;
            st  <= RD_I;
          end
        end
        FIN:     st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module ksa_sched_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic [CNT_W-1:0] cycles
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_we);

  // R7
  cycles_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cycles));

  // R7
  cycles_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cycles == $past(cycles) + 1'b1);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> cycles != '0);

endmodule

bind ksa_sched ksa_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .mem_we(mem_we), .cycles(cycles)
);

// File: tb/tb_ksa_sched.sv
`timescale 1ns/1ps
module tb_ksa_sched;
  localparam int CNT_W = 16;
  localparam int TOTAL = 2305;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] key = '0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, done;
  logic [CNT_W-1:0] cycles;

  logic [7:0] mem [256];
  logic [7:0] wa [1024];
  logic [7:0] wd [1024];
  int wn = 0;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  ksa_sched #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .done(done), .cycles(cycles)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (wn < 1024) begin
        wa[wn] = mem_addr;
        wd[wn] = mem_wdata;
      end
      wn = wn + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] k, input bit inject);
    int ref_s [256];
    int jj, tmp, kbv, done_t, done_n, idmis, mis, late_we;
    for (int n = 0; n < 256; n++) ref_s[n] = n;
    jj = 0;
    for (int n = 0; n < 256; n++) begin
      kbv = (k >> (8 * (n % 3))) & 8'hFF;
      jj = (jj + ref_s[n] + kbv) % 256;
      tmp = ref_s[n]; ref_s[n] = ref_s[jj]; ref_s[jj] = tmp;
    end
    @(negedge clk);
    key = k;
    start = 1'b1;
    wn = 0;
    @(negedge clk);
    start = 1'b0;
    done_t = -1; done_n = 0; late_we = 0;
    for (int t = 1; t <= 2310; t++) begin
      if (t == 257) begin
        idmis = 0;
        for (int n = 0; n < 256; n++) if (mem[n] != n[7:0]) idmis++;
        chk(idmis == 0 && wn == 256, "R1 identity fill mismatches", idmis, 0);
      end
      if (inject && t == 1000) start = 1'b1;
      if (inject && t == 1001) start = 1'b0;
      if (done) begin
        done_n++;
        if (done_t < 0) done_t = t;
      end
      if (t > TOTAL && mem_we) late_we++;
      if (t == TOTAL + 1)
        chk(cycles == TOTAL, "R7 cycle count after done", int'(cycles), TOTAL);
      @(negedge clk);
    end
    chk(done_t == TOTAL, "R4 done cycle", done_t, TOTAL);
    chk(done_n == 1, "R6 done pulse width", done_n, 1);
    chk(late_we == 0, "R6 writes after done", late_we, 0);
    chk(wn == 768, "R5 total writes", wn, 768);
    chk(wa[256] == 8'd0 && wd[256] == k[7:0], "R5 first swap write data", int'(wd[256]), int'(k[7:0]));
    chk(wa[257] == k[7:0] && wd[257] == 8'd0, "R5 second swap write addr", int'(wa[257]), int'(k[7:0]));
    mis = 0;
    for (int n = 0; n < 256; n++) if (mem[n] != ref_s[n][7:0]) mis++;
    chk(mis == 0, "R2 R3 R10 scrambled table mismatches", mis, 0);
    if (inject) chk(mis == 0 && done_t == TOTAL, "R8 busy start ignored", done_t, TOTAL);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 256; n++) mem[n] = 8'hA5;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9 done in reset", int'(done), 0);
    chk(mem_we == 1'b0, "R9 mem_we in reset", int'(mem_we), 0);
    chk(cycles == '0, "R9 cycles in reset", int'(cycles), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cycles == '0 && !mem_we, "R9 idle after reset", int'(cycles), 0);
    run(24'h000000, 1'b0);
    run(24'hFFFFFF, 1'b0);
    run(24'hAAFF00, 1'b0);
    run(24'h123456, 1'b1);
    run(24'h010203, 1'b0);
    run(24'h010203, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule